// File: doc/BRIEF.md
# Min-Heap Sift-Up Insert Controller

This block adds one unsigned value to a binary min-heap held in an external single-ported memory. The memory reads without a clock and writes on the clock edge that ends the cycle. Slot 0 of the memory is left unused, so the element at index `i` has its parent at `i >> 1`. The block takes a one-cycle `start` pulse together with the value and the current element count. It bumps the count through a one-cycle strobe. It then climbs from the new leaf toward the root, moving each larger ancestor down one level, until the value reaches the slot where it belongs. The block raises `done` for one cycle when the heap is consistent again.

Each cycle allows only one memory access, so every step of the climb takes two states. `ST_PARENT` reads the ancestor into a register, and `ST_COMP` compares it and, if it must move, writes it one level down. The final write of the new value waits for `ST_DONE`.

The states are `ST_IDLE`, `ST_INIT`, `ST_PARENT`, `ST_COMP` and `ST_DONE`. The transitions are:
- IDLE to INIT on `start`.
- INIT to PARENT when the old count is non-zero; INIT to DONE when it is zero.
- PARENT to COMP, always.
- COMP to PARENT when the value is smaller than the ancestor and the ancestor was not the root; COMP to DONE otherwise.
- DONE to IDLE, always.

The controller assumes the heap is not full when `start` arrives.

Top module: `heap_insert_ctrl`

## Requirements
- R1: While reset is high and afterwards with no `start`, the controller sits in `ST_IDLE` with `mem_wen`, `size_inc` and `done` all low.
- R2: The value on `din` is captured on the `start` cycle in `ST_IDLE`. Later changes on `din` have no effect on what is stored.
- R3: In the cycle after `start`, `size_inc` is high for exactly one cycle, and the working index becomes `count + 1`. Exactly one `size_inc` pulse occurs per insert.
- R4: When the count is zero at `start`, no ancestor is read, the value is written to address 1, and `done` rises one cycle after INIT.
- R5: In `ST_PARENT` the controller drives the address `idx >> 1` with `mem_wen` low and latches `mem_rdata`.
- R6: In `ST_COMP`, if the value is strictly smaller than the latched ancestor, the ancestor is written to address `idx` and the index halves. The climb stops at the root or at the first ancestor that is not larger.
- R7: `ST_DONE` writes the value to address `idx` and raises `done` for exactly one cycle, then returns to `ST_IDLE`.
- R8: If `k` is the number of ancestors compared, `done` is high `1 + 2k` clock edges after the edge that accepts `start`.
- R9: A `start` pulse that arrives while an insert is in progress is ignored.
- R10: Address 0 is never written.
- R11: A value equal to its ancestor stays below that ancestor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to insert `din` |
| din | input | DATA_W | Value to insert |
| count | input | ADDR_W | Element count before the insert |
| mem_rdata | input | DATA_W | Asynchronous memory read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wen | output | 1 | 1 = write at the end of this cycle, 0 = read |
| size_inc | output | 1 | One-cycle strobe that increments the external count |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths: 8-bit data and 8-bit addresses. It places a memory model and a count register around the block. With these widths, the insert sequence covers every case of interest:
- inserting into an empty heap;
- climbs that stop partway up;
- climbs that reach the root;
- equal keys;
- the extreme values 0 and 255.

It also covers a `start` pulse and a change on `din` that arrive in the middle of a climb. For each insert, the bench predicts the memory image and the exact `done` latency from a software model of the heap.

// File: rtl/heap_ins_pkg.sv
package heap_ins_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_PARENT,
        ST_COMP,
        ST_DONE
    } ins_state_t;

endpackage

// File: rtl/heap_ins_fsm.sv
module heap_ins_fsm
    import heap_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       heap_nonempty,
    input  logic       val_lt_par,
    input  logic       par_is_root,
    output ins_state_t state
);

    ins_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = start ? ST_INIT : ST_IDLE;
            ST_INIT:   nxt = heap_nonempty ? ST_PARENT : ST_DONE;
            ST_PARENT: nxt = ST_COMP;
            ST_COMP:   nxt = (val_lt_par && !par_is_root) ? ST_PARENT : ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // R9: a start pulse outside IDLE never redirects the sequence
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARENT) |=> (state == ST_COMP));

    // R7: DONE always hands back to IDLE
    a_r7_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/heap_ins_datapath.sv
module heap_ins_datapath
    import heap_ins_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ins_state_t        state,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] count,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] idx,
    output logic [ADDR_W-1:0] par_idx,
    output logic [DATA_W-1:0] val_q,
    output logic [DATA_W-1:0] par_q,
    output logic              val_lt_par,
    output logic              par_is_root,
    output logic              heap_nonempty
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            val_q <= '0;
            par_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) val_q <= din;
                ST_INIT:   idx <= count + ONE;
                ST_PARENT: par_q <= mem_rdata;
                ST_COMP:   if (val_lt_par) idx <= par_idx;
                default:   ;
            endcase
        end
    end

    assign par_idx       = idx >> 1;
    assign par_is_root   = (par_idx == ONE);
    assign val_lt_par    = (val_q < par_q);
    assign heap_nonempty = (count != '0);

    // R6: a move in COMP halves the working index
    a_r6_idx_climbs: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMP && val_lt_par) |=> (idx == ($past(idx) >> 1)));

    // R2: the captured value holds for the whole operation
    a_r2_value_held: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(val_q) || $past(state) == ST_IDLE);

endmodule

// File: rtl/heap_ins_drive.sv
module heap_ins_drive
    import heap_ins_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  ins_state_t        state,
    input  logic [ADDR_W-1:0] idx,
    input  logic [ADDR_W-1:0] par_idx,
    input  logic [DATA_W-1:0] val_q,
    input  logic [DATA_W-1:0] par_q,
    input  logic              val_lt_par,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wen,
    output logic              size_inc,
    output logic              done
);

    always_comb begin
        mem_addr  = idx;
        mem_wdata = val_q;
        mem_wen   = 1'b0;
        size_inc  = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_INIT:   size_inc = 1'b1;
            ST_PARENT: mem_addr = par_idx;
            ST_COMP: begin
                mem_wdata = par_q;
                mem_wen   = val_lt_par;
            end
            ST_DONE: begin
                mem_wen = 1'b1;
                done    = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/heap_insert_ctrl.sv
module heap_insert_ctrl
    import heap_ins_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] count,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wen,
    output logic              size_inc,
    output logic              done
);

    ins_state_t        state;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] par_idx;
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] par_q;
    logic              val_lt_par;
    logic              par_is_root;
    logic              heap_nonempty;

    heap_ins_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .heap_nonempty (heap_nonempty),
        .val_lt_par    (val_lt_par),
        .par_is_root   (par_is_root),
        .state         (state)
    );

    heap_ins_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .start         (start),
        .din           (din),
        .count         (count),
        .mem_rdata     (mem_rdata),
        .idx           (idx),
        .par_idx       (par_idx),
        .val_q         (val_q),
        .par_q         (par_q),
        .val_lt_par    (val_lt_par),
        .par_is_root   (par_is_root),
        .heap_nonempty (heap_nonempty)
    );

    heap_ins_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drv (
        .state      (state),
        .idx        (idx),
        .par_idx    (par_idx),
        .val_q      (val_q),
        .par_q      (par_q),
        .val_lt_par (val_lt_par),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_wen    (mem_wen),
        .size_inc   (size_inc),
        .done       (done)
    );

    // R3: the increment strobe lasts one cycle and only follows an accepted start
    a_r3_inc_single: assert property (@(posedge clk) disable iff (rst)
        size_inc |=> !size_inc);
    a_r3_inc_after_start: assert property (@(posedge clk) disable iff (rst)
        size_inc |-> $past(start));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: slot 0 is never a write target
    a_r10_no_slot0: assert property (@(posedge clk) disable iff (rst)
        mem_wen |-> (mem_addr != '0));

    // R5: an ancestor read cycle is never a write
    a_r5_read_only: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARENT) |-> !mem_wen);

    // R1: reset leaves every strobe low
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!mem_wen && !size_inc && !done));

endmodule

// File: tb/sim_heap_insert_ctrl.sv
module sim_heap_insert_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] count;
    logic [7:0] mem_rdata;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_wen;
    logic       size_inc;
    logic       done;

    always #5 clk = ~clk;

    heap_insert_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din       (din),
        .count     (count),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wen   (mem_wen),
        .size_inc  (size_inc),
        .done      (done)
    );

    // memory and count models around the block
    logic [7:0] mem [256];
    assign mem_rdata = mem[mem_addr];

    always_ff @(posedge clk) begin
        if (mem_wen) mem[mem_addr] <= mem_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (size_inc) count <= count + 8'd1;
    end

    int inc_pulses = 0;
    int slot0_writes = 0;
    always @(posedge clk) begin
        if (!rst && size_inc) inc_pulses++;
        if (!rst && mem_wen && mem_addr == 8'd0) slot0_writes++;
    end

    // reference heap
    logic [7:0] ref_heap [256];
    int ref_size = 0;
    int checks = 0;
    int fails = 0;

    localparam logic [7:0] VEC [12] = '{8'd50, 8'd40, 8'd60, 8'd30, 8'd45, 8'd20,
                                         8'd20, 8'd70, 8'd10, 8'd55, 8'd5, 8'd90};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_insert(input logic [7:0] v);
        int i;
        int k;
        ref_size++;
        i = ref_size;
        k = 0;
        while (i > 1) begin
            k++;
            if (v < ref_heap[i/2]) begin
                ref_heap[i] = ref_heap[i/2];
                i = i / 2;
            end else begin
                break;
            end
        end
        ref_heap[i] = v;
        return k;
    endfunction

    task automatic compare_heap(input string req);
        int bad;
        bad = 0;
        for (int i = 1; i <= ref_size; i++) begin
            if (mem[i] !== ref_heap[i]) begin
                if (bad == 0)
                    $display("FAIL %s: slot %0d actual %0d expected %0d", req, i, mem[i], ref_heap[i]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    task automatic do_insert(input logic [7:0] v, input bit wiggle, input bit busy);
        int k;
        int cnt;
        int inc0;
        int n;
        inc0 = inc_pulses;
        n = ref_size + 1;
        k = ref_insert(v);
        @(negedge clk);
        din = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (wiggle) din = ~v;
        cnt = 0;
        while (!done && cnt < 1000) begin
            if (cnt == 0)
                check(size_inc === 1'b1, "R3 inc in INIT", int'(size_inc), 1);
            if (cnt == 1 && k > 0)
                check(mem_addr == 8'(n >> 1) && !mem_wen, "R5 parent read addr", int'(mem_addr), n >> 1);
            start = busy && (cnt == 2);
            if (busy && cnt == 2) din = 8'd1;
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == 1 + 2 * k, "R8 latency", cnt, 1 + 2 * k);
        check(mem_wen === 1'b1 && mem_wdata == v, "R7 final write value", int'(mem_wdata), int'(v));
        @(negedge clk);
        check(done === 1'b0, "R7 done one cycle", int'(done), 0);
        check(inc_pulses - inc0 == 1, "R3 one inc per insert", inc_pulses - inc0, 1);
        check(int'(count) == ref_size, "R3 count", int'(count), ref_size);
        compare_heap(wiggle ? "R2 din ignored" : (busy ? "R9 heap" : "R6 heap"));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int inc_snap;
        mem[0] = 8'hA5;
        for (int i = 1; i < 256; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check(!mem_wen && !size_inc && !done, "R1 reset quiet", int'({mem_wen, size_inc, done}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!mem_wen && !size_inc && !done, "R1 idle quiet", int'({mem_wen, size_inc, done}), 0);

        // R4: first insert goes straight to slot 1
        do_insert(VEC[0], 1'b0, 1'b0);
        check(mem[1] == VEC[0], "R4 empty insert slot1", int'(mem[1]), int'(VEC[0]));

        // table walk; includes equal keys for R11
        for (int j = 1; j < 12; j++) do_insert(VEC[j], 1'b0, 1'b0);
        compare_heap("R11 equal keys kept");

        // R2: din changes mid-operation
        do_insert(8'd3, 1'b1, 1'b0);
        // R9: start while busy, long climb
        do_insert(8'd0, 1'b0, 1'b1);
        inc_snap = inc_pulses;
        repeat (4) @(negedge clk);
        check(inc_pulses == inc_snap && !done, "R9 busy start dropped", inc_pulses - inc_snap, 0);
        // extremes
        do_insert(8'd255, 1'b0, 1'b0);

        // R10: slot 0 untouched
        check(slot0_writes == 0 && mem[0] == 8'hA5, "R10 slot0", slot0_writes, 0);

        // reset and insert into empty heap again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_size = 0;
        do_insert(8'd77, 1'b0, 1'b0);
        check(mem[1] == 8'd77, "R4 after reset", int'(mem[1]), 77);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule